// File: doc/BRIEF.md
# Buffered Parallel Printer-Port Transmitter

This block sits on the host side of a byte-wide, printer-style parallel link. Software, or any producer logic, pushes bytes into a small FIFO through a one-cycle write port. The block then drains that FIFO without further help. It launches the oldest byte only when the peripheral reports that it is not busy. It drives the byte onto the data lines for a setup window, then pulses the active-low strobe for a fixed width. After that it keeps the byte in place for a hold window before it considers the next byte.

All three windows are counted in system clock cycles, and each comes from a parameter of at least one. The busy and acknowledge inputs come from off-chip. Each passes through a two-stage synchronizer before any decision uses it. Pacing relies on busy alone. The falling edge of the acknowledge pulse only sets a sticky flag, and that flag drives an interrupt request when the enable input is high.

Two more sticky error flags report problems. One reports a write that was dropped because the FIFO was full. The other reports a peripheral that kept busy high for longer than a programmable number of cycles. A single clear input resets all three sticky flags. The reset input is asynchronous when asserted and is released to the logic through a two-stage synchronizer.

Top module: `pport_tx`

## Requirements
- R1: While reset is applied, and for two clock edges after its release, the outputs hold these values: `strobe_n`=1, `pd_out`=0, `fifo_empty`=1, `fifo_full`=0, and `ack_flag`, `irq`, `ovf_err`, `tout_err` all 0.
- R2: A write with `wr_en`=1 stores `wr_data` when the FIFO is not full. `fifo_full` is 1 exactly when DEPTH bytes are held, and `fifo_empty` is 1 exactly when none are held.
- R3: A write while `fifo_full`=1 is discarded and sets the sticky `ovf_err` on the next edge. The stored contents and their order are unchanged.
- R4: A byte is launched only when the FIFO is non-empty, the transmitter is idle and the synchronized busy is 0. The synchronized busy is the value of `busy_in` two edges earlier. The byte launched is always the oldest one stored, and it appears on `pd_out` after the launching edge.
- R5: The new byte is on `pd_out` for exactly SETUP_CYC cycles before `strobe_n` falls.
- R6: `strobe_n` stays low for exactly STROBE_CYC consecutive cycles per byte.
- R7: `pd_out` stays unchanged for at least HOLD_CYC cycles after `strobe_n` rises. The next launch can happen no earlier than the edge that ends those HOLD_CYC cycles.
- R8: A falling edge of the synchronized `ack_n` (1 then 0, two edges behind the pin) sets the sticky `ack_flag`. `irq` equals `ack_flag` AND `irq_en`.
- R9: When the synchronized busy has been 1 for TIMEOUT_CYC consecutive cycles, the sticky `tout_err` is set. Any cycle in which the synchronized busy is 0 restarts the count.
- R10: `flag_clr`=1 clears `ack_flag`, `ovf_err` and `tout_err` on the next edge. A flag that is set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe into the FIFO |
| wr_data | input | 8 | Byte to enqueue |
| irq_en | input | 1 | Routes the acknowledge flag to `irq` |
| flag_clr | input | 1 | Clears the sticky flags |
| busy_in | input | 1 | Peripheral busy, asynchronous |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| pd_out | output | 8 | Parallel data lines |
| strobe_n | output | 1 | Active-low data strobe |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| fifo_empty | output | 1 | FIFO holds no bytes |
| ack_flag | output | 1 | Sticky acknowledge-seen flag |
| irq | output | 1 | Interrupt request |
| ovf_err | output | 1 | Sticky dropped-write flag |
| tout_err | output | 1 | Sticky busy-timeout flag |

## Verification
The bench builds the block with DEPTH=4, SETUP_CYC=3, STROBE_CYC=4, HOLD_CYC=2 and TIMEOUT_CYC=40. With a shallow FIFO, a short write burst against a stalled peripheral reaches the full flag and the dropped-write path. Short windows make the setup, strobe and hold counts visible one cycle at a time across several bytes. With a limit of forty cycles, a deliberate busy stall crosses the timeout quickly. Between stalls, the peripheral model answers each strobe with busy and a delayed acknowledge pulse, so pacing, the interrupt path and clearing a flag in the same cycle that it is set all occur in one short run.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } tx_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;

endmodule

// File: rtl/pport_fifo.sv
module pport_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          drop
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          push, pop;

  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;
  assign drop  = wr_en && full;
  assign rd_data = mem[rd_ptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    count_d  = count_q;
    if (push && !pop)      count_d = count_q + 1'b1;
    else if (pop && !push) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_data;
  end

  // R4: the sequencer never asks for a byte the FIFO does not hold
  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_i)
    rd_en |-> !empty);

  // R3: a write refused while full leaves the occupancy untouched
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_en && full && !rd_en) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/pport_seq.sv
module pport_seq
  import pport_pkg::*;
#(
  parameter int SETUP_CYC  = 50,
  parameter int STROBE_CYC = 100,
  parameter int HOLD_CYC   = 50
) (
  input  logic       clk,
  input  logic       rst_i,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_rdata,
  input  logic       busy_s,
  output logic       fifo_pop,
  output logic [7:0] pd_out,
  output logic       strobe_n
);

  localparam int MAXC = max3(SETUP_CYC, STROBE_CYC, HOLD_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  tx_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [7:0]     data_q, data_d;
  logic           cnt_en;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    data_d   = data_q;
    fifo_pop = 1'b0;
    cnt_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!fifo_empty && !busy_s) begin
          fifo_pop = 1'b1;
          data_d   = fifo_rdata;
          cnt_d    = '0;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        cnt_en = 1'b1;
        if (cnt_q == CW'(SETUP_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_STROBE;
        end
      end
      ST_STROBE: begin
        cnt_en = 1'b1;
        if (cnt_q == CW'(STROBE_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        cnt_en = 1'b1;
        if (cnt_q == CW'(HOLD_CYC - 1)) begin
          cnt_d   = '0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (cnt_en && (state_d == state_q)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
    end
  end

  assign pd_out   = data_q;
  assign strobe_n = (state_q != ST_STROBE);

  // R7: the data lines only move on a launch out of the idle state
  p_data_held_r7: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(data_q) |-> ($past(state_q) == ST_IDLE));

  // R6: while the strobe is low the data lines do not move
  p_strobe_data_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (!strobe_n && !$past(strobe_n)) |-> $stable(pd_out));

endmodule

// File: rtl/pport_tx.sv
module pport_tx #(
  parameter int DEPTH       = 16,
  parameter int SETUP_CYC   = 50,
  parameter int STROBE_CYC  = 100,
  parameter int HOLD_CYC    = 50,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       irq_en,
  input  logic       flag_clr,
  input  logic       busy_in,
  input  logic       ack_n,
  output logic [7:0] pd_out,
  output logic       strobe_n,
  output logic       fifo_full,
  output logic       fifo_empty,
  output logic       ack_flag,
  output logic       irq,
  output logic       ovf_err,
  output logic       tout_err
);

  localparam int TCW = $clog2(TIMEOUT_CYC + 1);

  logic       rst_s1_q, rst_i;
  logic [1:0] sync_out;
  logic       busy_s, ack_s, ack_d_q;
  logic       pop, drop, ack_fall, tout_hit;
  logic [7:0] fifo_rdata;
  logic [TCW-1:0] tcnt_q, tcnt_d;
  logic       ack_flag_q, ovf_q, tout_q;
  logic       ack_flag_d, ovf_d, tout_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_i    <= rst_s1_q;
    end
  end

  pport_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk     (clk),
    .rst_i   (rst_i),
    .d_async ({ack_n, busy_in}),
    .d_sync  (sync_out)
  );
  assign busy_s = sync_out[0];
  assign ack_s  = sync_out[1];

  pport_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk     (clk),
    .rst_i   (rst_i),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (fifo_rdata),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .drop    (drop)
  );

  pport_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_i      (rst_i),
    .fifo_empty (fifo_empty),
    .fifo_rdata (fifo_rdata),
    .busy_s     (busy_s),
    .fifo_pop   (pop),
    .pd_out     (pd_out),
    .strobe_n   (strobe_n)
  );

  assign ack_fall = ack_d_q && !ack_s;
  assign tout_hit = busy_s && (tcnt_q == TCW'(TIMEOUT_CYC - 1));

  always_comb begin
    if (!busy_s)       tcnt_d = '0;
    else if (tout_hit) tcnt_d = tcnt_q;
    else               tcnt_d = tcnt_q + 1'b1;
    ack_flag_d = (ack_flag_q && !flag_clr) || ack_fall;
    ovf_d      = (ovf_q      && !flag_clr) || drop;
    tout_d     = (tout_q     && !flag_clr) || tout_hit;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ack_d_q    <= 1'b1;
      tcnt_q     <= '0;
      ack_flag_q <= 1'b0;
      ovf_q      <= 1'b0;
      tout_q     <= 1'b0;
    end else begin
      ack_d_q    <= ack_s;
      tcnt_q     <= tcnt_d;
      ack_flag_q <= ack_flag_d;
      ovf_q      <= ovf_d;
      tout_q     <= tout_d;
    end
  end

  assign ack_flag = ack_flag_q;
  assign ovf_err  = ovf_q;
  assign tout_err = tout_q;
  assign irq      = ack_flag_q && irq_en;

  // R9: the timeout flag only rises after a cycle with busy seen high
  p_timeout_busy_r9: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(tout_err) |-> $past(busy_s));

  // R4: a launch never happens while the synchronized busy is high
  p_launch_ready_r4: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(pop) |-> !busy_s);

  // R8: the acknowledge flag rises only after the synchronized line went low
  p_ack_edge_r8: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(ack_flag) |-> !$past(ack_s));

endmodule

// File: tb/pport_tx_bench.sv
module pport_tx_bench;

  localparam int DEPTH = 4;
  localparam int SETUP = 3;
  localparam int STRB  = 4;
  localparam int HOLD  = 2;
  localparam int TOUT  = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, irq_en, flag_clr, busy_in, ack_n;
  logic [7:0] wr_data;
  logic [7:0] pd_out;
  logic       strobe_n, fifo_full, fifo_empty, ack_flag, irq, ovf_err, tout_err;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pport_tx #(
    .DEPTH(DEPTH), .SETUP_CYC(SETUP), .STROBE_CYC(STRB),
    .HOLD_CYC(HOLD), .TIMEOUT_CYC(TOUT)
  ) u_pport_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_en(irq_en), .flag_clr(flag_clr), .busy_in(busy_in), .ack_n(ack_n),
    .pd_out(pd_out), .strobe_n(strobe_n), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .ack_flag(ack_flag), .irq(irq),
    .ovf_err(ovf_err), .tout_err(tout_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  byte unsigned q[$];
  int  m_rs1, m_rs2, m_st, m_cnt, m_data, m_tc;
  int  b1, b2, a1, a2, ad;
  int  f_ack, f_ovf, f_tout;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0;
      m_st = 0; m_cnt = 0; m_data = 0; m_tc = 0;
      b1 = 0; b2 = 0; a1 = 1; a2 = 1; ad = 1;
      f_ack = 0; f_ovf = 0; f_tout = 0;
      q.delete();
    end else if (m_rs2 == 0) begin
      m_rs2 = m_rs1; m_rs1 = 1;
    end else begin
      int  sz, fall, hit;
      sz   = q.size();
      fall = (ad == 1 && a2 == 0);
      hit  = (b2 == 1 && m_tc == TOUT - 1);
      case (m_st)
        0: if (sz != 0 && b2 == 0) begin
             m_data = q.pop_front(); m_st = 1; m_cnt = 0;
           end
        1: if (m_cnt == SETUP - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
        2: if (m_cnt == STRB  - 1) begin m_st = 3; m_cnt = 0; end else m_cnt++;
        default: if (m_cnt == HOLD - 1) begin m_st = 0; m_cnt = 0; end else m_cnt++;
      endcase
      if (wr_en) begin
        if (sz < DEPTH) q.push_back(wr_data);
      end
      f_ack  = ((f_ack  && !flag_clr) || fall) ? 1 : 0;
      f_ovf  = ((f_ovf  && !flag_clr) || (wr_en && sz >= DEPTH)) ? 1 : 0;
      f_tout = ((f_tout && !flag_clr) || hit) ? 1 : 0;
      if (b2 == 0) m_tc = 0; else if (!hit) m_tc++;
      ad = a2; a2 = a1; a1 = ack_n;
      b2 = b1; b1 = busy_in;
    end
  end

  // per-cycle comparison away from the active edge
  int since_rise = 100;
  logic [7:0] last_pd;
  logic       last_stb = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 R5 pd_out", pd_out, m_data);
      chk("R6 strobe_n", strobe_n, (m_st != 2));
      chk("R2 fifo_full", fifo_full, (q.size() == DEPTH));
      chk("R2 fifo_empty", fifo_empty, (q.size() == 0));
      chk("R8 ack_flag", ack_flag, f_ack);
      chk("R8 irq", irq, (f_ack && irq_en));
      chk("R3 ovf_err", ovf_err, f_ovf);
      chk("R9 tout_err", tout_err, f_tout);
      if (since_rise < HOLD) chk("R7 hold", pd_out, last_pd);
      if (strobe_n && !last_stb) since_rise = 0; else since_rise++;
      last_stb = strobe_n;
      last_pd  = pd_out;
    end
  end

  // ---------------- peripheral model ----------------
  int  p_st = 0, p_cnt = 0;
  bit  force_busy = 1'b0;
  int  p_delay = 8;
  always @(posedge clk) begin
    #2;
    case (p_st)
      0: if (!strobe_n) begin p_st = 1; p_cnt = 0; end
      1: begin p_cnt++; if (p_cnt == p_delay) begin ack_n = 1'b0; p_st = 2; p_cnt = 0; end end
      default: begin p_cnt++; if (p_cnt == 6) begin ack_n = 1'b1; p_st = 0; end end
    endcase
    busy_in = force_busy || (p_st != 0);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [7:0] b);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_data = b;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; irq_en = 1'b0;
    flag_clr = 1'b0; busy_in = 1'b0; ack_n = 1'b1;
    #3;
    // R1: values during reset
    chk("R1 strobe_n", strobe_n, 1); chk("R1 pd_out", pd_out, 0);
    chk("R1 empty", fifo_empty, 1);  chk("R1 full", fifo_full, 0);
    chk("R1 flags", {ack_flag, irq, ovf_err, tout_err}, 0);
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 after release", {strobe_n, fifo_empty, ovf_err}, 3'b110);

    // R2 R4 R5 R6 R7: a short stream, interrupt enabled
    irq_en = 1'b1;
    push(8'hA5); push(8'h3C); push(8'hFF);
    cyc(120);

    // R3: stall the peripheral and overfill the shallow FIFO
    force_busy = 1'b1;
    cyc(3);
    for (int i = 0; i < DEPTH + 2; i++) push(8'h10 + 8'(i));
    cyc(2);
    chk("R3 full while stalled", fifo_full, 1);
    chk("R3 overflow flagged", ovf_err, 1);
    force_busy = 1'b0;
    cyc(200);
    chk("R2 drained", fifo_empty, 1);

    // R10: clear all flags
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0; cyc(1);
    chk("R10 cleared", {ack_flag, ovf_err, tout_err}, 0);

    // R9: long busy stall crosses the limit
    force_busy = 1'b1;
    cyc(TOUT + 5);
    chk("R9 timeout set", tout_err, 1);
    force_busy = 1'b0;

    // R8: irq masked while the flag stays visible; R10 clear held across acks
    irq_en = 1'b0;
    push(8'h81);
    flag_clr = 1'b1;
    cyc(40);
    flag_clr = 1'b0;
    push(8'h42);
    cyc(40);
    chk("R8 flag without irq", {ack_flag, irq}, 2'b10);

    // slower peripheral, back-to-back bytes
    p_delay = 15;
    irq_en = 1'b1;
    for (int i = 0; i < 3; i++) push(8'hC0 ^ 8'(i * 7));
    cyc(200);
    chk("R2 final empty", fifo_empty, 1);
    finish_run();
  end

endmodule